// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a processor and its memory and turns every virtual address into a physical one. It does this by reading a page-table entry from a single flat table in memory. It keeps no translation cache, so each access makes two memory round trips. The first reads the entry and the second carries out the real access. A base register gives the table's location, and rewriting it moves the block to a different address space.

The processor side takes one request at a time: a virtual address, a read/write flag, write data and a supervisor flag. The upper part of the address is the virtual page number, and it indexes the table directly. A 32-bit entry holds these fields:

| Bits | Meaning |
|------|---------|
| 0 | valid |
| 1 | readable |
| 2 | writable |
| 3 | supervisor-only |
| 31:12 | physical page number |

The physical address is the physical page number followed by the untouched 12-bit page offset. When the entry is missing, the block reports a page fault. When the entry forbids the access, it reports a protection fault. In both cases no physical access is made. The requester handles the fault and then reissues the same address.

Top module: `pt_xlate`

## Requirements
- R1: After reset `cpu_req_ready` is 1, `mem_req_valid` and `cpu_rsp_valid` are 0, and `cpu_fault` is 0.
- R2: The first memory request after a request is accepted is a read of the entry at the base register value plus the virtual page number (`cpu_vaddr[31:12]`) times 4.
- R3: When the entry permits the access, the second memory request goes to the physical page number (entry bits 31:12) concatenated with `cpu_vaddr[11:0]`. A read then returns the memory response data on `cpu_rsp_data` with `cpu_fault` = 0.
- R4: A permitted write sends `cpu_wdata` with `mem_req_write` = 1 on the physical request. The memory response completes it with `cpu_fault` = 0.
- R5: An entry with bit 0 = 0 yields `cpu_fault` = 1 (page fault) and no physical request. Validity is checked before any permission bit.
- R6: A user access (`cpu_super` = 0) to an entry with bit 3 = 1 yields `cpu_fault` = 2 (protection) and no physical request. A supervisor access to the same entry succeeds.
- R7: A write to an entry with bit 2 = 0 yields `cpu_fault` = 2. A read from an entry with bit 1 = 0 also yields `cpu_fault` = 2. In both cases no physical request is made.
- R8: Only one translation is in flight. `cpu_req_ready` stays 0 from acceptance until the response cycle, and a request presented meanwhile causes no memory traffic.
- R9: `cpu_fault` and `cpu_fault_vaddr` (the faulting virtual address) hold their values after a fault response until the next request is accepted. They are then cleared.
- R10: A retry of a faulted address, after its entry has been made valid, completes as a normal hit.
- R11: A write to the base register takes effect for the next accepted request, so that request reads its entry from the new table.
- R12: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request's address, write flag and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New table base address |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_vaddr | input | 32 | Virtual address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Write data |
| cpu_super | input | 1 | 1 = supervisor privilege |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_data | output | 32 | Read data (0 for writes and faults) |
| cpu_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| cpu_fault_vaddr | output | 32 | Virtual address of the last fault |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_write | output | 1 | Memory write |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 32 | Memory response data |

## Verification
The bench builds the block with its default values: a 32-bit virtual address, a 12-bit offset and 32-bit entries and data. With these values, entry addresses land at base plus four times the page number, and the physical page number fills bits 31:12. This lets one small sparse memory model hold two separate tables and every data page the bench uses. One scenario makes the memory withhold its ready on alternate cycles, which exercises the stall path of both the entry fetch and the physical access.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W = 32,
  parameter int OFS_W = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] BASE_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_we,
  input  logic [DW-1:0]   base_wdata,
  input  logic            cpu_req_valid,
  output logic            cpu_req_ready,
  input  logic [VA_W-1:0] cpu_vaddr,
  input  logic            cpu_write,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic            cpu_super,
  output logic            cpu_rsp_valid,
  output logic [DW-1:0]   cpu_rsp_data,
  output logic [1:0]      cpu_fault,
  output logic [VA_W-1:0] cpu_fault_vaddr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [DW-1:0]   mem_req_addr,
  output logic            mem_req_write,
  output logic [DW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data
);
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PPN_W  = DW - OFS_W;
  localparam int ENT_SH = $clog2(DW / 8);
  localparam int B_V = 0, B_R = 1, B_W = 2, B_S = 3;
  localparam logic [1:0] F_NONE = 2'd0, F_PAGE = 2'd1, F_PROT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_PTE_REQ, S_PTE_WAIT, S_DAT_REQ, S_DAT_WAIT, S_RESP} st_t;

  st_t             st;
  logic [DW-1:0]   base_q, pte_addr_q, wd_q, rdata_q;
  logic [VA_W-1:0] va_q, fva_q;
  logic [PPN_W-1:0] ppn_q;
  logic            wr_q, sup_q;
  logic [1:0]      fault_q;
  logic            accept, deny;
  logic [DW-1:0]   vpn_ext;

  assign accept  = cpu_req_valid && cpu_req_ready;
  assign vpn_ext = {{(DW-VPN_W){1'b0}}, cpu_vaddr[VA_W-1:OFS_W]};
  assign deny    = (!sup_q && mem_rsp_data[B_S]) ||
                   ( wr_q && !mem_rsp_data[B_W]) ||
                   (!wr_q && !mem_rsp_data[B_R]);

  assign cpu_req_ready   = (st == S_IDLE);
  assign cpu_rsp_valid   = (st == S_RESP);
  assign cpu_rsp_data    = rdata_q;
  assign cpu_fault       = fault_q;
  assign cpu_fault_vaddr = fva_q;
  assign mem_req_valid   = (st == S_PTE_REQ) || (st == S_DAT_REQ);
  assign mem_req_addr    = (st == S_DAT_REQ) ? {ppn_q, va_q[OFS_W-1:0]} : pte_addr_q;
  assign mem_req_write   = (st == S_DAT_REQ) && wr_q;
  assign mem_req_wdata   = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= BASE_RST;
      pte_addr_q <= '0;
      wd_q       <= '0;
      rdata_q    <= '0;
      va_q       <= '0;
      fva_q      <= '0;
      ppn_q      <= '0;
      wr_q       <= 1'b0;
      sup_q      <= 1'b0;
      fault_q    <= F_NONE;
    end else begin
      if (base_we) base_q <= base_wdata;
      case (st)
        S_IDLE: if (accept) begin
          pte_addr_q <= base_q + (vpn_ext << ENT_SH);
          va_q       <= cpu_vaddr;
          wr_q       <= cpu_write;
          wd_q       <= cpu_wdata;
          sup_q      <= cpu_super;
          fault_q    <= F_NONE;
          fva_q      <= '0;
          st         <= S_PTE_REQ;
        end
        S_PTE_REQ: if (mem_req_ready) st <= S_PTE_WAIT;
        S_PTE_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[B_V]) begin
            fault_q <= F_PAGE;
            fva_q   <= va_q;
            rdata_q <= '0;
            st      <= S_RESP;
          end else if (deny) begin
            fault_q <= F_PROT;
            fva_q   <= va_q;
            rdata_q <= '0;
            st      <= S_RESP;
          end else begin
            ppn_q <= mem_rsp_data[DW-1:OFS_W];
            st    <= S_DAT_REQ;
          end
        end
        S_DAT_REQ: if (mem_req_ready) st <= S_DAT_WAIT;
        S_DAT_WAIT: if (mem_rsp_valid) begin
          rdata_q <= wr_q ? '0 : mem_rsp_data;
          st      <= S_RESP;
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  a_r8_rsp_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> cpu_req_ready && !cpu_rsp_valid);

  a_r12_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (cpu_rsp_valid || ($stable(cpu_fault) && $stable(cpu_fault_vaddr))));

  a_r5_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fault != 2'd3);

  a_r5_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_fault != F_NONE) |-> cpu_rsp_data == '0);
endmodule

// File: tb/pt_xlate_tb.sv
module pt_xlate_tb;
  logic        clk = 0, rst_n = 0;
  logic        base_we = 0;
  logic [31:0] base_wdata = 0;
  logic        cpu_req_valid = 0, cpu_write = 0, cpu_super = 0;
  logic [31:0] cpu_vaddr = 0, cpu_wdata = 0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_data, cpu_fault_vaddr;
  logic [1:0]  cpu_fault;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  pt_xlate u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr [0:63];
  logic        log_wr [0:63];
  logic [31:0] log_wd [0:63];
  int          log_n = 0;
  bit          stall_mode = 0;
  int          stab_err = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    bit          prev_stall = 0;
    logic [31:0] prev_addr = 0, prev_wd = 0;
    logic        prev_wr = 0;
    forever begin
      @(posedge clk);
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr ||
                         mem_req_write != prev_wr || mem_req_wdata != prev_wd))
        stab_err++;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      prev_wr    = mem_req_write;
      prev_wd    = mem_req_wdata;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (log_n < 64) begin
          log_addr[log_n] = mem_req_addr;
          log_wr[log_n]   = mem_req_write;
          log_wd[log_n]   = mem_req_wdata;
        end
        log_n++;
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          mem_rsp_data <= 32'h0;
        end else begin
          mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        end
        mem_rsp_valid <= 1'b1;
      end
      mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_up();
  end

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1; base_wdata = b;
    @(negedge clk);
    base_we = 0;
  endtask

  task automatic xact(input logic [31:0] va, input bit wr, input logic [31:0] wd, input bit sup,
                      output logic [31:0] rd, output logic [1:0] flt, output logic [31:0] fva);
    log_n = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_vaddr = va; cpu_write = wr; cpu_wdata = wd; cpu_super = sup;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
    while (!cpu_rsp_valid) @(negedge clk);
    rd = cpu_rsp_data; flt = cpu_fault; fva = cpu_fault_vaddr;
  endtask

  logic [31:0] rd, fva;
  logic [1:0]  flt;

  task automatic t_reset();
    check(cpu_req_ready === 1'b1, "R1 ready", {31'b0, cpu_req_ready}, 1);
    check(mem_req_valid === 1'b0 && cpu_rsp_valid === 1'b0, "R1 valids",
          {30'b0, mem_req_valid, cpu_rsp_valid}, 0);
    check(cpu_fault === 2'd0, "R1 fault", {30'b0, cpu_fault}, 0);
  endtask

  task automatic t_read_hit();
    xact(32'h0000_5ABC, 0, 0, 0, rd, flt, fva);
    check(log_n == 2, "R3 two requests", log_n, 2);
    check(log_addr[0] == 32'h0001_0014 && !log_wr[0], "R2 entry addr", log_addr[0], 32'h0001_0014);
    check(log_addr[1] == 32'h0004_2ABC && !log_wr[1], "R3 phys addr", log_addr[1], 32'h0004_2ABC);
    check(rd == 32'hDEAD_BEEF && flt == 0, "R3 read data", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_hit();
    xact(32'h0000_6010, 1, 32'h1234_5678, 0, rd, flt, fva);
    check(log_n == 2 && log_addr[0] == 32'h0001_0018, "R2 write entry addr", log_addr[0], 32'h0001_0018);
    check(log_addr[1] == 32'h0007_7010 && log_wr[1] && log_wd[1] == 32'h1234_5678,
          "R4 write forwarded", log_wd[1], 32'h1234_5678);
    check(flt == 0 && mem[32'h0007_7010] == 32'h1234_5678, "R4 write ack", {30'b0, flt}, 0);
  endtask

  task automatic t_page_fault();
    xact(32'h0000_7444, 0, 0, 0, rd, flt, fva);
    check(flt == 2'd1, "R5 page fault code", {30'b0, flt}, 1);
    check(log_n == 1, "R5 no phys access", log_n, 1);
    check(fva == 32'h0000_7444, "R5 fault vaddr", fva, 32'h0000_7444);
  endtask

  task automatic t_super();
    xact(32'h0000_8020, 0, 0, 0, rd, flt, fva);
    check(flt == 2'd2 && log_n == 1, "R6 user to supervisor page", {30'b0, flt}, 2);
    xact(32'h0000_8020, 0, 0, 1, rd, flt, fva);
    check(flt == 0 && rd == 32'h5555_AAAA && log_n == 2, "R6 supervisor allowed", rd, 32'h5555_AAAA);
  endtask

  task automatic t_perm();
    xact(32'h0000_5ABC, 1, 32'hFFFF_0000, 0, rd, flt, fva);
    check(flt == 2'd2 && log_n == 1, "R7 write to read-only", {30'b0, flt}, 2);
    check(mem[32'h0004_2ABC] == 32'hDEAD_BEEF, "R7 memory untouched", mem[32'h0004_2ABC], 32'hDEAD_BEEF);
    xact(32'h0000_9100, 0, 0, 1, rd, flt, fva);
    check(flt == 2'd2 && log_n == 1, "R7 read of non-readable", {30'b0, flt}, 2);
    xact(32'h0000_9100, 1, 32'h0BAD_F00D, 1, rd, flt, fva);
    check(flt == 0 && mem[32'h0006_0100] == 32'h0BAD_F00D, "R7 write to write-only ok", {30'b0, flt}, 0);
  endtask

  task automatic t_hold();
    bit ok = 1;
    xact(32'h0000_7444, 0, 0, 0, rd, flt, fva);
    repeat (5) begin
      @(negedge clk);
      if (cpu_fault != 2'd1 || cpu_fault_vaddr != 32'h0000_7444) ok = 0;
    end
    check(ok, "R9 fault held while idle", {30'b0, cpu_fault}, 1);
    @(negedge clk);
    cpu_req_valid = 1; cpu_vaddr = 32'h0000_5ABC; cpu_write = 0; cpu_super = 0;
    @(negedge clk);
    cpu_req_valid = 0;
    check(cpu_fault == 0 && cpu_fault_vaddr == 0, "R9 cleared on accept", cpu_fault_vaddr, 0);
    while (!cpu_rsp_valid) @(negedge clk);
  endtask

  task automatic t_retry();
    xact(32'h0000_7444, 0, 0, 0, rd, flt, fva);
    check(flt == 2'd1, "R10 first try faults", {30'b0, flt}, 1);
    mem[32'h0001_001C] = 32'h0008_8003;
    mem[32'h0008_8444] = 32'h7777_0001;
    xact(32'h0000_7444, 0, 0, 0, rd, flt, fva);
    check(flt == 0 && rd == 32'h7777_0001, "R10 retry hits", rd, 32'h7777_0001);
  endtask

  task automatic t_busy();
    bit ok = 1;
    log_n = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_vaddr = 32'h0000_5ABC; cpu_write = 0; cpu_super = 0;
    @(negedge clk);
    cpu_vaddr = 32'h0000_6010;
    while (!cpu_rsp_valid) begin
      if (cpu_req_ready) ok = 0;
      @(negedge clk);
    end
    cpu_req_valid = 0;
    rd = cpu_rsp_data;
    @(negedge clk); @(negedge clk);
    check(ok, "R8 ready low while busy", 0, 0);
    check(log_n == 2 && rd == 32'hDEAD_BEEF, "R8 second request ignored", log_n, 2);
  endtask

  task automatic t_base();
    set_base(32'h0002_0000);
    xact(32'h0000_5ABC, 0, 0, 0, rd, flt, fva);
    check(log_addr[0] == 32'h0002_0014, "R11 new table", log_addr[0], 32'h0002_0014);
    check(rd == 32'hCAFE_0001 && flt == 0, "R11 new mapping", rd, 32'hCAFE_0001);
    set_base(32'h0001_0000);
  endtask

  task automatic t_stall();
    stab_err = 0;
    stall_mode = 1;
    xact(32'h0000_6010, 1, 32'hA5A5_5A5A, 0, rd, flt, fva);
    xact(32'h0000_5ABC, 0, 0, 0, rd, flt, fva);
    stall_mode = 0;
    check(rd == 32'hDEAD_BEEF && flt == 0, "R12 read under stalls", rd, 32'hDEAD_BEEF);
    check(mem[32'h0007_7010] == 32'hA5A5_5A5A, "R12 write under stalls", mem[32'h0007_7010], 32'hA5A5_5A5A);
    check(stab_err == 0, "R12 held request", stab_err, 0);
  endtask

  initial begin
    mem[32'h0001_0014] = 32'h0004_2003;
    mem[32'h0004_2ABC] = 32'hDEAD_BEEF;
    mem[32'h0001_0018] = 32'h0007_7007;
    mem[32'h0001_001C] = 32'h0000_0008;
    mem[32'h0001_0020] = 32'h0005_000B;
    mem[32'h0005_0020] = 32'h5555_AAAA;
    mem[32'h0001_0024] = 32'h0006_0005;
    mem[32'h0002_0014] = 32'h0009_9003;
    mem[32'h0009_9ABC] = 32'hCAFE_0001;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    set_base(32'h0001_0000);
    t_read_hit();
    t_write_hit();
    t_page_fault();
    t_super();
    t_perm();
    t_hold();
    t_busy();
    t_base();
    t_stall();
    t_retry();
    finish_up();
  end
endmodule